// File: doc/BRIEF.md
# SIMD Pre-Widening Add/Subtract Unit

This unit executes the widening add and widening subtract forms of a 32-bit SIMD instruction that works on registers of different lengths. It keeps a private file of doubleword (64-bit) registers. Each register can be read as a low or a high 32-bit half.

In the **long** forms, narrow elements of 8, 16 or 32 bits are taken from both sources. Each element is sign- or zero-extended to double width, and the pair is added or subtracted.

In the **wide** forms, the first operand is already double width and comes from an even/odd register pair. Only the second operand is widened.

An instruction word arrives with a one-cycle valid strobe while the unit is idle. The unit either rejects the encoding with a one-cycle undefined pulse, or it runs two passes:

- Pass 0 combines the low halves and writes the even destination register.
- Pass 1 combines the high halves and writes the next register.
- A one-cycle done pulse follows the second write.

All operands for both passes are captured when the instruction is accepted. A destination that overlaps a source therefore still gives the mathematically correct result.

A simple load port and a read port give the surrounding logic access to the register file.

Top module: `simd_widen_addsub`

## Requirements
- R1: An instruction is accepted only if it has all of the following; any other word raises undef:
  - bits [31:25] = 1111001
  - bit 23 = 1
  - bit 6 = 0
  - bit 4 = 0
  - operation field bits [11:8] = 0000 (add-long), 0001 (add-wide), 0010 (subtract-long) or 0011 (subtract-wide).
- R2: A size field (bits [21:20]) value of 3 raises undef. Values 0, 1 and 2 select 8-, 16- and 32-bit narrow elements.
- R3: An odd destination index raises undef. For the wide forms, an odd first-operand index also raises undef. An odd first-operand index is legal for the long forms.
- R4: Undef is a one-cycle pulse in the cycle after acceptance. The unit does not become busy, does not pulse done, and writes no register.
- R5: The long forms extend every narrow element of both sources to double width. Bit 24 selects the extension: 0 means sign extension, 1 means zero extension. The extended pairs are then added lane by lane.
- R6: The wide forms use the first operand unchanged at double width. Pass 0 reads it from the even register and pass 1 from the following odd register. Only the second operand is extended.
- R7: Each double-width lane is added or subtracted modulo its own width. No carry or borrow crosses a lane boundary, and there is no saturation.
- R8: Register indices are formed as follows:
  - destination: bit 22 above bits [15:12]
  - first operand: bit 7 above bits [19:16]
  - second operand: bit 5 above bits [3:0]

  Pass 0 uses the low 32-bit source halves and writes the destination. Pass 1 uses the high halves and writes destination+1.
- R9: Both passes use the register contents as they were when the instruction was accepted. This holds even when the destination equals a source.
- R10: After a legal instruction is accepted, busy is high for exactly two cycles. Done then pulses for one cycle, as busy falls. A valid strobe while busy is ignored. All three flags are low after reset.
- R11: A load-port write is ignored while busy. A load-port write in the same cycle as acceptance lands in the register, and the instruction sees the previous contents.
- R12: With the file sized to 16 registers, any register index with bit 4 set raises undef.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the register file |
| insn_valid | input | 1 | Instruction strobe, taken when idle |
| insn | input | 32 | Instruction word |
| busy | output | 1 | High during the two passes |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | One-cycle rejected-encoding pulse |
| rf_we | input | 1 | Load-port write enable |
| rf_waddr | input | 5 | Load-port register index |
| rf_wdata | input | 64 | Load-port write data |
| rf_raddr | input | 5 | Read-port register index |
| rf_rdata | output | 64 | Read-port data (combinational) |

## Verification
Two pairs of functions can fall in the same cycle.

- **Load-port write and instruction acceptance.** The bench raises the strobe and a write to the second source register on the same falling edge. It expects the instruction to use the old contents, and a later read to show the new value.
- **Pass-0 write and a register that pass 1 still needs.** The bench sets the destination equal to the first or the second source, in both long and wide forms. It compares both destination registers against results computed from the values loaded before the instruction.

A strobe and a load write issued while busy are also judged: both must leave no trace.

// File: rtl/simd_widen_addsub.sv
module simd_widen_addsub #(
  parameter int NREGS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_valid,
  input  logic [31:0] insn,
  output logic        busy,
  output logic        done,
  output logic        undef,
  input  logic        rf_we,
  input  logic [4:0]  rf_waddr,
  input  logic [63:0] rf_wdata,
  input  logic [4:0]  rf_raddr,
  output logic [63:0] rf_rdata
);
  localparam int AW = $clog2(NREGS);

  typedef enum logic [1:0] {S_IDLE, S_P0, S_P1} st_t;

  function automatic logic [63:0] widen(input logic [31:0] w, input logic [1:0] sz, input logic zx);
    logic [63:0] r;
    r = '0;
    case (sz)
      2'd0: for (int i = 0; i < 4; i++) r[16*i +: 16] = {{8{~zx & w[8*i+7]}}, w[8*i +: 8]};
      2'd1: for (int i = 0; i < 2; i++) r[32*i +: 32] = {{16{~zx & w[16*i+15]}}, w[16*i +: 16]};
      default: r = {{32{~zx & w[31]}}, w};
    endcase
    return r;
  endfunction

  function automatic logic [63:0] lane_op(input logic [63:0] a, input logic [63:0] b,
                                          input logic [1:0] sz, input logic sub);
    logic [63:0] r;
    r = '0;
    case (sz)
      2'd0: for (int i = 0; i < 4; i++)
              r[16*i +: 16] = sub ? a[16*i +: 16] - b[16*i +: 16] : a[16*i +: 16] + b[16*i +: 16];
      2'd1: for (int i = 0; i < 2; i++)
              r[32*i +: 32] = sub ? a[32*i +: 32] - b[32*i +: 32] : a[32*i +: 32] + b[32*i +: 32];
      default: r = sub ? a - b : a + b;
    endcase
    return r;
  endfunction

  logic [63:0] rf [NREGS];
  st_t         st;
  logic [63:0] a0_q, a1_q, b_q;
  logic [1:0]  sz_q;
  logic        zx_q, sub_q, wide_q;
  logic [4:0]  d_q;

  wire [1:0] f_sz   = insn[21:20];
  wire [3:0] f_op   = insn[11:8];
  wire [4:0] f_d    = {insn[22], insn[15:12]};
  wire [4:0] f_n    = {insn[7],  insn[19:16]};
  wire [4:0] f_m    = {insn[5],  insn[3:0]};
  wire       f_wide = f_op[0];

  wire fixed_ok = (insn[31:25] == 7'b1111001) && insn[23] && !insn[6] && !insn[4]
                  && (f_op[3:2] == 2'b00);
  wire hi_bad   = (NREGS < 32) && (f_d[4] | f_n[4] | f_m[4]);
  wire reject   = !fixed_ok || (f_sz == 2'b11) || f_d[0] || (f_wide && f_n[0]) || hi_bad;
  wire accept   = insn_valid && (st == S_IDLE);

  wire [4:0] f_n1 = f_n | 5'd1;

  wire        pass1 = (st == S_P1);
  wire [31:0] b_nar = pass1 ? b_q[63:32] : b_q[31:0];
  wire [63:0] a_src = pass1 ? a1_q : a0_q;
  wire [63:0] opa   = wide_q ? a_src : widen(pass1 ? a_src[63:32] : a_src[31:0], sz_q, zx_q);
  wire [63:0] opb   = widen(b_nar, sz_q, zx_q);
  wire [63:0] res   = lane_op(opa, opb, sz_q, sub_q);

  assign busy     = (st != S_IDLE);
  assign rf_rdata = rf[rf_raddr[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      undef  <= 1'b0;
      a0_q   <= '0;
      a1_q   <= '0;
      b_q    <= '0;
      sz_q   <= '0;
      zx_q   <= 1'b0;
      sub_q  <= 1'b0;
      wide_q <= 1'b0;
      d_q    <= '0;
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
    end else begin
      done  <= 1'b0;
      undef <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            if (reject) begin
              undef <= 1'b1;
            end else begin
              a0_q   <= rf[f_n[AW-1:0]];
              a1_q   <= f_wide ? rf[f_n1[AW-1:0]] : rf[f_n[AW-1:0]];
              b_q    <= rf[f_m[AW-1:0]];
              sz_q   <= f_sz;
              zx_q   <= insn[24];
              sub_q  <= f_op[1];
              wide_q <= f_wide;
              d_q    <= f_d;
              st     <= S_P0;
            end
          end
          if (rf_we) rf[rf_waddr[AW-1:0]] <= rf_wdata;
        end
        S_P0: begin
          rf[d_q[AW-1:0]] <= res;
          st <= S_P1;
        end
        default: begin
          rf[d_q[AW-1:0] | AW'(1)] <= res;
          st   <= S_IDLE;
          done <= 1'b1;
        end
      endcase
    end
  end
endmodule

module simd_widen_addsub_chk (
  input logic clk,
  input logic rst_n,
  input logic insn_valid,
  input logic busy,
  input logic done,
  input logic undef
);
  // R4
  undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> (!busy && !done));

  // R4
  undef_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> ($past(insn_valid) && !$past(busy)));

  // R10
  busy_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

  // R10
  busy_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy);

  // R10
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind simd_widen_addsub simd_widen_addsub_chk u_chk (
  .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid),
  .busy(busy), .done(done), .undef(undef)
);

// File: tb/simd_widen_addsub_test.sv
`timescale 1ns/1ps
module simd_widen_addsub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [31:0] insn = '0;
  logic        busy, done, undef;
  logic        rf_we = 1'b0;
  logic [4:0]  rf_waddr = '0;
  logic [63:0] rf_wdata = '0;
  logic [4:0]  rf_raddr = '0;
  logic [63:0] rf_rdata;

  logic        s_valid = 1'b0;
  logic [31:0] s_insn = '0;
  logic        s_busy, s_done, s_undef;
  logic [63:0] s_rdata;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  simd_widen_addsub uut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .busy(busy), .done(done), .undef(undef),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
  );

  simd_widen_addsub #(.NREGS(16)) uut16 (
    .clk(clk), .rst_n(rst_n), .insn_valid(s_valid), .insn(s_insn),
    .busy(s_busy), .done(s_done), .undef(s_undef),
    .rf_we(1'b0), .rf_waddr(5'd0), .rf_wdata(64'd0),
    .rf_raddr(5'd0), .rf_rdata(s_rdata)
  );

  localparam logic [63:0] DA = 64'hF0E1_80FF_7F01_FF80;
  localparam logic [63:0] DB = 64'h0123_FF01_8000_7FFF;
  localparam logic [63:0] DC = 64'h8000_0001_FFFF_7FFE;
  localparam logic [63:0] DE = 64'h7FFF_FFFF_0000_8000;
  localparam logic [63:0] SENT = 64'hDEAD_BEEF_5A5A_A5A5;

  function automatic logic [31:0] enc(input bit zx, input logic [1:0] sz, input logic [3:0] op,
                                      input logic [4:0] d, input logic [4:0] n, input logic [4:0] m);
    return {7'b1111001, zx, 1'b1, d[4], sz, n[3:0], d[3:0], op, n[4], 1'b0, m[4], 1'b0, m[3:0]};
  endfunction

  function automatic longint unsigned ext(input longint unsigned v, input int w, input bit zx);
    longint unsigned nm;
    nm = (64'd1 << w) - 1;
    if (!zx && (((v >> (w - 1)) & 1) == 1)) return v | ~nm;
    return v;
  endfunction

  function automatic logic [63:0] model(input logic [63:0] a, input logic [31:0] b, input int sz,
                                        input bit zx, input bit sub, input bit wide);
    int w;
    longint unsigned nm, wm, x, y, r, z;
    w  = 8 << sz;
    nm = (64'd1 << w) - 1;
    wm = (w == 32) ? 64'hFFFF_FFFF_FFFF_FFFF : (64'd1 << (2 * w)) - 1;
    r  = 0;
    for (int k = 0; k < 32 / w; k++) begin
      if (wide) x = (a >> (2 * w * k)) & wm;
      else      x = ext((a >> (w * k)) & nm, w, zx);
      y = ext(({32'd0, b} >> (w * k)) & nm, w, zx);
      z = sub ? x - y : x + y;
      r = r | ((z & wm) << (2 * w * k));
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [4:0] a, input logic [63:0] v);
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = a; rf_wdata = v;
    @(negedge clk);
    rf_we = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [63:0] v);
    rf_raddr = a;
    #1;
    v = rf_rdata;
  endtask

  task automatic issue(input logic [31:0] w, output logic u1, output logic b1,
                       output logic b2, output logic d3, output logic b3);
    @(negedge clk);
    insn_valid = 1'b1; insn = w;
    @(negedge clk);
    insn_valid = 1'b0;
    u1 = undef; b1 = busy;
    @(negedge clk);
    b2 = busy;
    @(negedge clk);
    d3 = done; b3 = busy;
  endtask

  task automatic run_ok(input string tag, input logic [31:0] w);
    logic u1, b1, b2, d3, b3;
    issue(w, u1, b1, b2, d3, b3);
    chk({tag, " R10 timing"}, {59'd0, u1, b1, b2, d3, b3}, 64'b01110);
  endtask

  task automatic run_bad(input string tag, input logic [31:0] w, input logic [4:0] watch);
    logic u1, b1, b2, d3, b3;
    logic [63:0] v;
    load(watch, SENT);
    load(watch | 5'd1, SENT);
    issue(w, u1, b1, b2, d3, b3);
    chk({tag, " R4 undef pulse"}, {59'd0, u1, b1, b2, d3, b3}, 64'b10000);
    peek(watch, v);
    chk({tag, " R4 no write lo"}, v, SENT);
    peek(watch | 5'd1, v);
    chk({tag, " R4 no write hi"}, v, SENT);
  endtask

  task automatic t_reset();
    logic [63:0] v;
    peek(5'd9, v);
    chk("R10 reset flags", {61'd0, busy, done, undef}, 64'd0);
    chk("R10 reset file", v, 64'd0);
  endtask

  task automatic t_long(input bit zx, input int sz, input bit sub);
    logic [63:0] v;
    load(5'd2, DA);
    load(5'd7, DB);
    run_ok(sub ? "R7 sub-long" : "R5 add-long",
           enc(zx, 2'(sz), sub ? 4'b0010 : 4'b0000, 5'd12, 5'd2, 5'd7));
    peek(5'd12, v);
    chk(sub ? "R7 R8 pass0 sub-long" : "R5 R8 pass0 add-long", v, model({32'd0, DA[31:0]}, DB[31:0], sz, zx, sub, 1'b0));
    peek(5'd13, v);
    chk(sub ? "R7 R8 pass1 sub-long" : "R5 R8 pass1 add-long", v, model({32'd0, DA[63:32]}, DB[63:32], sz, zx, sub, 1'b0));
  endtask

  task automatic t_wide(input bit zx, input int sz, input bit sub);
    logic [63:0] v;
    load(5'd4, DC);
    load(5'd5, DE);
    load(5'd9, DB);
    run_ok("R6 wide", enc(zx, 2'(sz), sub ? 4'b0011 : 4'b0001, 5'd16, 5'd4, 5'd9));
    peek(5'd16, v);
    chk("R6 R8 wide pass0 high index", v, model(DC, DB[31:0], sz, zx, sub, 1'b1));
    peek(5'd17, v);
    chk("R6 R8 wide pass1 high index", v, model(DE, DB[63:32], sz, zx, sub, 1'b1));
  endtask

  task automatic t_odd_n_long();
    logic [63:0] v;
    load(5'd3, DB);
    load(5'd6, DA);
    run_ok("R3 long odd n", enc(1'b0, 2'd1, 4'b0000, 5'd18, 5'd3, 5'd6));
    peek(5'd19, v);
    chk("R3 long odd n legal", v, model({32'd0, DB[63:32]}, DA[63:32], 1, 1'b0, 1'b0, 1'b0));
  endtask

  task automatic t_overlap();
    logic [63:0] v;
    load(5'd20, DA);
    load(5'd3, DB);
    run_ok("R9 d==n", enc(1'b0, 2'd0, 4'b0000, 5'd20, 5'd20, 5'd3));
    peek(5'd21, v);
    chk("R9 d==n pass1", v, model({32'd0, DA[63:32]}, DB[63:32], 0, 1'b0, 1'b0, 1'b0));
    load(5'd22, DB);
    load(5'd1, DA);
    run_ok("R9 d==m", enc(1'b1, 2'd1, 4'b0010, 5'd22, 5'd1, 5'd22));
    peek(5'd22, v);
    chk("R9 d==m pass0", v, model({32'd0, DA[31:0]}, DB[31:0], 1, 1'b1, 1'b1, 1'b0));
    peek(5'd23, v);
    chk("R9 d==m pass1", v, model({32'd0, DA[63:32]}, DB[63:32], 1, 1'b1, 1'b1, 1'b0));
    load(5'd24, DC);
    load(5'd25, DE);
    load(5'd11, DA);
    run_ok("R9 wide d==n", enc(1'b0, 2'd2, 4'b0011, 5'd24, 5'd24, 5'd11));
    peek(5'd25, v);
    chk("R9 wide d==n pass1", v, model(DE, DA[63:32], 2, 1'b0, 1'b1, 1'b1));
  endtask

  task automatic t_busy_ignore();
    logic [63:0] v;
    logic d3;
    load(5'd2, DA);
    load(5'd7, DB);
    load(5'd28, SENT);
    load(5'd30, SENT);
    @(negedge clk);
    insn_valid = 1'b1; insn = enc(1'b1, 2'd0, 4'b0000, 5'd12, 5'd2, 5'd7);
    @(negedge clk);
    insn = enc(1'b0, 2'd0, 4'b0000, 5'd28, 5'd2, 5'd7);
    rf_we = 1'b1; rf_waddr = 5'd30; rf_wdata = 64'h1234;
    @(negedge clk);
    insn_valid = 1'b0; rf_we = 1'b0;
    @(negedge clk);
    d3 = done;
    chk("R10 done after busy-time strobe", {63'd0, d3}, 64'd1);
    @(negedge clk);
    chk("R10 no second instruction", {62'd0, busy, undef}, 64'd0);
    peek(5'd28, v);
    chk("R10 strobe while busy ignored", v, SENT);
    peek(5'd30, v);
    chk("R11 load while busy ignored", v, SENT);
    peek(5'd13, v);
    chk("R5 zero-extend pass1", v, model({32'd0, DA[63:32]}, DB[63:32], 0, 1'b1, 1'b0, 1'b0));
  endtask

  task automatic t_same_cycle();
    logic [63:0] v;
    load(5'd2, DC);
    load(5'd7, DB);
    @(negedge clk);
    insn_valid = 1'b1; insn = enc(1'b0, 2'd2, 4'b0000, 5'd26, 5'd2, 5'd7);
    rf_we = 1'b1; rf_waddr = 5'd7; rf_wdata = DE;
    @(negedge clk);
    insn_valid = 1'b0; rf_we = 1'b0;
    repeat (3) @(negedge clk);
    peek(5'd26, v);
    chk("R11 accept sees old source", v, model({32'd0, DC[31:0]}, DB[31:0], 2, 1'b0, 1'b0, 1'b0));
    peek(5'd7, v);
    chk("R11 same-cycle load lands", v, DE);
  endtask

  task automatic t_small_file();
    logic u1, d3;
    @(negedge clk);
    s_valid = 1'b1; s_insn = enc(1'b0, 2'd0, 4'b0000, 5'd2, 5'd17, 5'd3);
    @(negedge clk);
    s_valid = 1'b0;
    u1 = s_undef;
    chk("R12 16-reg index bit4 undef", {63'd0, u1}, 64'd1);
    @(negedge clk);
    s_valid = 1'b1; s_insn = enc(1'b0, 2'd0, 4'b0000, 5'd2, 5'd1, 5'd3);
    @(negedge clk);
    s_valid = 1'b0;
    u1 = s_undef;
    repeat (2) @(negedge clk);
    d3 = s_done;
    chk("R12 16-reg low indices legal", {62'd0, u1, d3}, 64'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_long(1'b0, 0, 1'b0);
    t_long(1'b1, 1, 1'b0);
    t_long(1'b0, 2, 1'b1);
    t_long(1'b1, 0, 1'b1);
    t_long(1'b0, 1, 1'b1);
    t_long(1'b1, 2, 1'b0);
    t_wide(1'b0, 0, 1'b0);
    t_wide(1'b1, 1, 1'b1);
    t_wide(1'b0, 2, 1'b1);
    t_odd_n_long();
    run_bad("R2 size3", enc(1'b0, 2'd3, 4'b0000, 5'd14, 5'd2, 5'd7), 5'd14);
    run_bad("R3 odd d", enc(1'b0, 2'd0, 4'b0000, 5'd15, 5'd2, 5'd7), 5'd14);
    run_bad("R3 wide odd n", enc(1'b0, 2'd1, 4'b0001, 5'd14, 5'd5, 5'd7), 5'd14);
    run_bad("R1 opc 0100", enc(1'b0, 2'd0, 4'b0100, 5'd14, 5'd2, 5'd7), 5'd14);
    run_bad("R1 bit23 clear", enc(1'b0, 2'd0, 4'b0000, 5'd14, 5'd2, 5'd7) & ~32'h0080_0000, 5'd14);
    run_bad("R1 bit6 set", enc(1'b0, 2'd0, 4'b0000, 5'd14, 5'd2, 5'd7) | 32'h0000_0040, 5'd14);
    t_overlap();
    t_busy_ignore();
    t_same_cycle();
    t_small_file();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule